// File: doc/BRIEF.md
# Exception Return Frame Unwinder

This block carries out the return from an exception handler. When it gets a start pulse, it reads the saved stack frame one 16-bit word at a time through a memory read port. It then hands back the status register, the program counter and the stack pointer that the core should resume with. Memory read data is taken combinationally, in the same cycle as the address.

A parameter chooses one of three core variants:

- **Basic (0):** pops a status word and a 32-bit program counter, with no format check.
- **Intermediate (1):** reads the frame format from the top nibble of the word six bytes above the stack pointer. It accepts only format 0.
- **Advanced (2):** also accepts two more formats. Format 1 is a short frame that is discarded and followed by another frame. Format 2 is a long frame whose extra bytes are skipped.

When the block refuses a return, it raises a fault pulse carrying an exception vector number. The fault covers a start in user mode and an unsupported format. Taking the exception is left to the surrounding core.

Top module: `exc_return_unwinder`

## Requirements
- R1: A start with `supervisor` low makes no memory read. One cycle later it gives a `fault` pulse with `fault_vec` = 8, and `sp_out` is set to `sp_in`.
- R2: On the basic variant, the block reads the status word at SP, the program counter high word at SP+2 and the low word at SP+4. `done` rises 4 cycles after the start edge, with `sp_out` = SP+6.
- R3: On the intermediate variant, the first read is at SP+6 and the format is bits 15:12 of that word. A nonzero format gives a `fault` pulse with `fault_vec` = 14 two cycles after start, and `sp_out` equals the frame's SP.
- R4: On the intermediate variant with format 0, the block pops the status word, the program counter and the format word. `done` rises 6 cycles after start, with `sp_out` = SP+8.
- R5: On the advanced variant, format 0 behaves exactly as in R4.
- R6: On the advanced variant, format 1 pops the status word and applies it to `sr_out` at once. It then moves SP on by 8 bytes in total and decodes the format again at the new SP+6.
- R7: On the advanced variant, format 2 pops the status word, the program counter and the format word, and then skips 4 more bytes. The result is `sp_out` = SP+12, 6 cycles after start.
- R8: On the advanced variant, any format above 2 gives a `fault` pulse with `fault_vec` = 14. `sp_out` is then the SP of the frame whose format failed.
- R9: The 32-bit program counter is read high word first: `pc_out` = {word at lower address, word at higher address}.
- R10: A start while `busy` is high is ignored. `done` and `fault` are single-cycle pulses that never occur together.
- R11: `cost` reads 20 whenever `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a return sequence (taken when idle) |
| supervisor | input | 1 | Core is in supervisor mode |
| sp_in | input | 32 | Stack pointer at start |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 32 | Byte address of the 16-bit word read |
| mem_rdata | input | 16 | Read data, valid in the same cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse: return completed |
| fault | output | 1 | One-cycle pulse: return refused |
| fault_vec | output | 8 | Exception vector number on fault |
| sr_out | output | 16 | Restored status register |
| pc_out | output | 32 | Restored program counter |
| sp_out | output | 32 | Final stack pointer |
| cost | output | 8 | Reported cycle cost on completion |

## Verification
On every cycle, the assertions check the following:
- the user-mode refusal and its vector;
- that `done` and `fault` are exclusive single-cycle pulses;
- that the reported cost is 20;
- that the fault vector is legal for the variant;
- that `sp_out` and `sr_out` change only at the end of a step.

Only the bench scenarios can show the frame-specific results:
- the exact read addresses, through the restored words;
- the SP arithmetic for formats 0, 1 and 2;
- the chained format 1 walk, including the status word it applies before a later format failure;
- the latency of each path.

// File: rtl/exc_return_unwinder.sv
module exc_return_unwinder #(
  parameter int VARIANT  = 2,
  parameter int AW       = 32,
  parameter int COST     = 20,
  parameter int VEC_PRIV = 8,
  parameter int VEC_FMT  = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          supervisor,
  input  logic [AW-1:0] sp_in,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [15:0]   mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          fault,
  output logic [7:0]    fault_vec,
  output logic [15:0]   sr_out,
  output logic [31:0]   pc_out,
  output logic [AW-1:0] sp_out,
  output logic [7:0]    cost
);
  typedef enum logic [2:0] {S_IDLE, S_FMT, S_SR, S_PCH, S_PCL, S_FWD} st_t;

  localparam logic [AW-1:0] W2 = AW'(2);
  localparam logic [AW-1:0] W6 = AW'(6);
  localparam logic [AW-1:0] W8 = AW'(8);

  st_t           st;
  logic [AW-1:0] sp;
  logic [3:0]    fmt;
  logic [15:0]   sr_tmp;
  logic [31:0]   pc_tmp;

  wire [3:0] fmt_rd = mem_rdata[15:12];
  wire       fmt_ok = (VARIANT == 1) ? (fmt_rd == 4'd0) : (fmt_rd <= 4'd2);
  wire       chain  = (VARIANT == 2) && (fmt == 4'd1);

  assign busy     = (st != S_IDLE);
  assign mem_rd   = busy;
  assign mem_addr = (st == S_FMT) ? sp + W6 : sp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sp <= '0; fmt <= '0; sr_tmp <= '0; pc_tmp <= '0;
      done <= 1'b0; fault <= 1'b0; fault_vec <= '0;
      sr_out <= '0; pc_out <= '0; sp_out <= '0; cost <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (!supervisor) begin
            fault <= 1'b1; fault_vec <= 8'(VEC_PRIV); sp_out <= sp_in;
          end else begin
            sp  <= sp_in;
            fmt <= '0;
            st  <= (VARIANT == 0) ? S_SR : S_FMT;
          end
        end
        S_FMT: begin
          fmt <= fmt_rd;
          if (fmt_ok) st <= S_SR;
          else begin
            fault <= 1'b1; fault_vec <= 8'(VEC_FMT); sp_out <= sp; st <= S_IDLE;
          end
        end
        S_SR: begin
          if (chain) begin
            sr_out <= mem_rdata;
            sp     <= sp + W8;
            st     <= S_FMT;
          end else begin
            sr_tmp <= mem_rdata;
            sp     <= sp + W2;
            st     <= S_PCH;
          end
        end
        S_PCH: begin
          pc_tmp[31:16] <= mem_rdata;
          sp <= sp + W2;
          st <= S_PCL;
        end
        S_PCL: begin
          pc_tmp[15:0] <= mem_rdata;
          sp <= sp + W2;
          if (VARIANT == 0) begin
            done <= 1'b1; cost <= 8'(COST); sr_out <= sr_tmp;
            pc_out <= {pc_tmp[31:16], mem_rdata}; sp_out <= sp + W2;
            st <= S_IDLE;
          end else st <= S_FWD;
        end
        S_FWD: begin
          done <= 1'b1; cost <= 8'(COST); sr_out <= sr_tmp; pc_out <= pc_tmp;
          sp_out <= (VARIANT == 2 && fmt == 4'd2) ? sp + W6 : sp + W2;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/exc_return_unwinder_chk.sv
module exc_return_unwinder_chk #(
  parameter int VARIANT = 2,
  parameter int AW      = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          supervisor,
  input logic [AW-1:0] sp_in,
  input logic          mem_rd,
  input logic [AW-1:0] mem_addr,
  input logic [15:0]   mem_rdata,
  input logic          busy,
  input logic          done,
  input logic          fault,
  input logic [7:0]    fault_vec,
  input logic [15:0]   sr_out,
  input logic [31:0]   pc_out,
  input logic [AW-1:0] sp_out,
  input logic [7:0]    cost
);
  // R1
  user_mode_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !supervisor && !busy |=> fault && fault_vec == 8'd8 && !mem_rd);

  // R10
  outcome_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  // R10
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cost == 8'd20);

  // R3
  fault_vector_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> fault_vec == 8'd8 || (VARIANT != 0 && fault_vec == 8'd14));

  // R8
  sp_update_on_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp_out) |-> done || fault);

  // R6
  sr_update_in_sequence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sr_out) |-> $past(busy));
endmodule

bind exc_return_unwinder exc_return_unwinder_chk #(.VARIANT(VARIANT), .AW(AW)) u_chk (.*);

// File: tb/exc_return_unwinder_tb.sv
module exc_return_unwinder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [15:0] mem [0:63];
  logic [2:0]  start_v = '0;
  logic        sup_r = 1'b1;
  logic [31:0] sp_r = '0;

  wire         rd_v   [3];
  wire  [31:0] addr_v [3];
  wire  [15:0] rdat_v [3];
  wire         busy_v [3];
  wire         done_v [3];
  wire         flt_v  [3];
  wire  [7:0]  vec_v  [3];
  wire  [15:0] sr_v   [3];
  wire  [31:0] pc_v   [3];
  wire  [31:0] spo_v  [3];
  wire  [7:0]  cost_v [3];
  int          rd_cnt [3];

  int tests = 0;
  int fails = 0;

  assign rdat_v[0] = mem[addr_v[0][6:1]];
  assign rdat_v[1] = mem[addr_v[1][6:1]];
  assign rdat_v[2] = mem[addr_v[2][6:1]];

  exc_return_unwinder #(.VARIANT(0)) u_dut_v0 (
    .clk(clk), .rst_n(rst_n), .start(start_v[0]), .supervisor(sup_r), .sp_in(sp_r),
    .mem_rd(rd_v[0]), .mem_addr(addr_v[0]), .mem_rdata(rdat_v[0]), .busy(busy_v[0]),
    .done(done_v[0]), .fault(flt_v[0]), .fault_vec(vec_v[0]), .sr_out(sr_v[0]),
    .pc_out(pc_v[0]), .sp_out(spo_v[0]), .cost(cost_v[0]));
  exc_return_unwinder #(.VARIANT(1)) u_dut_v1 (
    .clk(clk), .rst_n(rst_n), .start(start_v[1]), .supervisor(sup_r), .sp_in(sp_r),
    .mem_rd(rd_v[1]), .mem_addr(addr_v[1]), .mem_rdata(rdat_v[1]), .busy(busy_v[1]),
    .done(done_v[1]), .fault(flt_v[1]), .fault_vec(vec_v[1]), .sr_out(sr_v[1]),
    .pc_out(pc_v[1]), .sp_out(spo_v[1]), .cost(cost_v[1]));
  exc_return_unwinder #(.VARIANT(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start_v[2]), .supervisor(sup_r), .sp_in(sp_r),
    .mem_rd(rd_v[2]), .mem_addr(addr_v[2]), .mem_rdata(rdat_v[2]), .busy(busy_v[2]),
    .done(done_v[2]), .fault(flt_v[2]), .fault_vec(vec_v[2]), .sr_out(sr_v[2]),
    .pc_out(pc_v[2]), .sp_out(spo_v[2]), .cost(cost_v[2]));

  always @(posedge clk) begin
    for (int i = 0; i < 3; i++) if (rd_v[i]) rd_cnt[i] <= rd_cnt[i] + 1;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put(input int a, input logic [15:0] d);
    mem[a[6:1]] = d;
  endtask

  task automatic run(input int v, input logic sup, input logic [31:0] sp,
                     output int lat, output int reads);
    int r0;
    r0 = rd_cnt[v];
    @(negedge clk);
    sup_r = sup; sp_r = sp; start_v[v] = 1'b1;
    @(negedge clk);
    start_v = '0; lat = 1;
    while (!(done_v[v] || flt_v[v]) && lat < 40) begin
      @(negedge clk); lat++;
    end
    reads = rd_cnt[v] - r0;
  endtask

  task automatic t_reset;
    chk(done_v[2] == 0 && flt_v[2] == 0 && busy_v[2] == 0, "reset outputs idle", {done_v[2], flt_v[2], busy_v[2]}, 0);
    chk(spo_v[2] == 0 && sr_v[2] == 0, "reset sp/sr zero", spo_v[2], 0);
  endtask

  task automatic t_priv;
    int lat, rd;
    for (int v = 0; v < 3; v += 2) begin
      run(v, 1'b0, 32'h40, lat, rd);
      chk(flt_v[v] && vec_v[v] == 8'd8, "R1 privilege vector", vec_v[v], 8);
      chk(lat == 1 && rd == 0, "R1 latency/no read", lat * 100 + rd, 100);
      chk(spo_v[v] == 32'h40 && !done_v[v], "R1 sp_out", spo_v[v], 32'h40);
    end
  endtask

  task automatic t_basic;
    int lat, rd;
    put(32'h20, 16'h2714); put(32'h22, 16'hDEAD); put(32'h24, 16'hBEEF); put(32'h26, 16'h5000);
    run(0, 1'b1, 32'h20, lat, rd);
    chk(done_v[0] && lat == 4, "R2 basic latency", lat, 4);
    chk(sr_v[0] == 16'h2714 && rd == 3, "R2 basic sr/reads", sr_v[0], 16'h2714);
    chk(pc_v[0] == 32'hDEADBEEF, "R9 pc high word first", pc_v[0], 32'hDEADBEEF);
    chk(spo_v[0] == 32'h26, "R2 basic sp", spo_v[0], 32'h26);
    chk(cost_v[0] == 8'd20, "R11 cost", cost_v[0], 20);
    @(negedge clk);
    chk(!done_v[0] && !flt_v[0], "R10 done single pulse", done_v[0], 0);
  endtask

  task automatic t_mid;
    int lat, rd;
    put(32'h30, 16'h2000); put(32'h32, 16'h0001); put(32'h34, 16'h2345); put(32'h36, 16'h0078);
    run(1, 1'b1, 32'h30, lat, rd);
    chk(done_v[1] && lat == 6 && rd == 5, "R4 mid fmt0 latency/reads", lat, 6);
    chk(sr_v[1] == 16'h2000 && pc_v[1] == 32'h00012345, "R4 mid sr/pc", pc_v[1], 32'h00012345);
    chk(spo_v[1] == 32'h38, "R4 mid sp", spo_v[1], 32'h38);
    put(32'h36, 16'h2008);
    run(1, 1'b1, 32'h30, lat, rd);
    chk(flt_v[1] && vec_v[1] == 8'd14 && lat == 2, "R3 mid bad format", vec_v[1], 14);
    chk(spo_v[1] == 32'h30 && !done_v[1], "R3 sp unchanged", spo_v[1], 32'h30);
  endtask

  task automatic t_adv_fmt0;
    int lat, rd;
    put(32'h36, 16'h0078);
    run(2, 1'b1, 32'h30, lat, rd);
    chk(done_v[2] && lat == 6, "R5 adv fmt0 latency", lat, 6);
    chk(pc_v[2] == 32'h00012345 && spo_v[2] == 32'h38, "R5 adv fmt0 sp", spo_v[2], 32'h38);
  endtask

  task automatic t_adv_fmt1;
    int lat, rd;
    put(32'h10, 16'h2700); put(32'h16, 16'h1000);
    put(32'h18, 16'h0004); put(32'h1A, 16'h00AB); put(32'h1C, 16'hCDEF); put(32'h1E, 16'h0010);
    run(2, 1'b1, 32'h10, lat, rd);
    chk(done_v[2] && lat == 8, "R6 fmt1 chain latency", lat, 8);
    chk(sr_v[2] == 16'h0004 && pc_v[2] == 32'h00ABCDEF, "R6 fmt1 chain sr/pc", pc_v[2], 32'h00ABCDEF);
    chk(spo_v[2] == 32'h20, "R6 fmt1 chain sp", spo_v[2], 32'h20);
  endtask

  task automatic t_adv_fmt2;
    int lat, rd;
    put(32'h40, 16'h2300); put(32'h42, 16'h1234); put(32'h44, 16'h5678); put(32'h46, 16'h2008);
    run(2, 1'b1, 32'h40, lat, rd);
    chk(done_v[2] && lat == 6, "R7 fmt2 latency", lat, 6);
    chk(pc_v[2] == 32'h12345678 && sr_v[2] == 16'h2300, "R7 fmt2 pc", pc_v[2], 32'h12345678);
    chk(spo_v[2] == 32'h4C, "R7 fmt2 sp", spo_v[2], 32'h4C);
  endtask

  task automatic t_adv_bad;
    int lat, rd;
    put(32'h1E, 16'h7000);
    run(2, 1'b1, 32'h10, lat, rd);
    chk(flt_v[2] && vec_v[2] == 8'd14 && lat == 4, "R8 bad format after chain", vec_v[2], 14);
    chk(spo_v[2] == 32'h18, "R8 sp at failing frame", spo_v[2], 32'h18);
    chk(sr_v[2] == 16'h2700, "R6 chained sr applied", sr_v[2], 16'h2700);
    put(32'h46, 16'h3000);
    run(2, 1'b1, 32'h40, lat, rd);
    chk(flt_v[2] && vec_v[2] == 8'd14 && spo_v[2] == 32'h40, "R8 format 3 refused", spo_v[2], 32'h40);
  endtask

  task automatic t_busy;
    int lat;
    int extra;
    @(negedge clk);
    sup_r = 1'b1; sp_r = 32'h20; start_v[0] = 1'b1;
    @(negedge clk);
    sp_r = 32'h40;
    @(negedge clk);
    start_v = '0; lat = 2;
    while (!done_v[0] && lat < 40) begin @(negedge clk); lat++; end
    chk(done_v[0] && lat == 4, "R10 start while busy ignored latency", lat, 4);
    chk(spo_v[0] == 32'h26 && pc_v[0] == 32'hDEADBEEF, "R10 busy result", spo_v[0], 32'h26);
    extra = 0;
    repeat (6) begin @(negedge clk); if (done_v[0] || flt_v[0]) extra++; end
    chk(extra == 0, "R10 no second outcome", extra, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    for (int i = 0; i < 3; i++) rd_cnt[i] = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_priv();
    t_basic();
    t_mid();
    t_adv_fmt0();
    t_adv_fmt1();
    t_adv_fmt2();
    t_adv_bad();
    t_busy();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule